// File: doc/BRIEF.md
# Monitor Host Handshake Sequencer

This block runs the opening exchange between a chip in debug-monitor mode and a host on a single serial line. A one-cycle start pulse arms it. It then receives exactly eight security bytes over a UART-style 8N1 link, with bit timing derived from the bus clock. The bus clock is the oscillator divided by four, so a 9.8304 MHz oscillator gives a 2.4576 MHz bus and 9600 baud at 256 bus cycles per bit. Each received byte is compared with the matching byte of a key supplied on a parallel input.

After the eighth byte, the sequencer holds its transmit line low for ten bit times as a break. It then releases the line and raises a ready-for-command flag. A security-pass flag reports whether every byte matched and was framed correctly. A failed comparison does not stop the break.

The controller has four states, and each transition is named here:
- `SEQ_IDLE` goes to `SEQ_COLLECT` on the start pulse.
- `SEQ_COLLECT` goes to `SEQ_BREAK` when the eighth byte completes.
- `SEQ_BREAK` goes to `SEQ_READY` when the break counter ends.
- `SEQ_READY` holds until reset.

The bit receiver has its own states. `RX_IDLE` goes to `RX_START` on a low line. `RX_START` goes to `RX_DATA` when the mid-start sample is low, and back to `RX_IDLE` when it is high. `RX_DATA` goes to `RX_STOP` after eight data samples. `RX_STOP` returns to `RX_IDLE` after the stop sample.

Top module: `mon_handshake_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `txd_o` is 1, `sec_pass_o` is 0 and `cmd_ready_o` is 0.
- R2: Only a `start_i` pulse in the idle state begins byte collection. Line activity before that pulse is not received. A `start_i` pulse during collection or after ready does not restart the count and does not change any output.
- R3: Received bytes are 8N1: one low start bit, eight data bits with the least significant bit first, and one stop bit. Each bit is sampled at its middle, with `BIT_CYCLES` bus cycles per bit (default 256).
- R4: A low pulse on the idle receive line that is shorter than half a bit is rejected and is not taken as a start bit.
- R5: Exactly eight bytes are received. No break and no ready appear before the eighth byte, and a break begins right after the eighth byte without any further input.
- R6: The break holds `txd_o` at 0 for exactly `BREAK_BITS`×`BIT_CYCLES` cycles (10 bit times). After that `txd_o` returns to 1 and stays at 1.
- R7: `cmd_ready_o` rises in the same cycle that `txd_o` returns high after the break, is 0 during the break, and stays at 1 until reset.
- R8: `sec_pass_o` is set only when received byte i equals key byte i for all i, where key byte i is `key_i[8i+7:8i]`. It is set in the first cycle of the break and holds until reset.
- R9: A stop bit sampled as 0 is a framing error, and that byte counts as a mismatch.
- R10: A mismatched byte does not prevent the break or the ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that arms byte collection |
| rxd_i | input | 1 | Serial receive line from the host, idle high |
| key_i | input | NUM_BYTES*8 | Expected security bytes, byte i in bits 8i+7:8i |
| txd_o | output | 1 | Serial transmit line to the host, idle high |
| sec_pass_o | output | 1 | All security bytes matched |
| cmd_ready_o | output | 1 | Break finished, ready for a command |

## Verification
Two events share a single clock edge: the verdict on the eighth byte and the start of the break. The bench provokes this by sending eight correct data bytes with a zero stop bit on the last one. It then judges that the break still has its full length and that the pass flag stays low. A second pairing also shares a cycle: the end of the break and the rise of the ready flag. This pairing is judged at the edge where the line returns high, where the bench requires ready to be set.

// File: rtl/mhs_pkg.sv
package mhs_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_COLLECT,
        SEQ_BREAK,
        SEQ_READY
    } seq_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

endpackage

// File: rtl/mhs_bit_rx.sv
module mhs_bit_rx
    import mhs_pkg::*;
#(
    parameter int BIT_CYCLES = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       rxd_i,
    output logic       vld_o,
    output logic [7:0] data_o,
    output logic       frame_ok_o
);
    localparam int CW   = $clog2(BIT_CYCLES);
    localparam int HALF = BIT_CYCLES / 2;

    rx_state_e      st_q;
    logic [CW-1:0]  cnt_q;
    logic [2:0]     bit_q;
    logic [1:0]     sync_q;
    logic           line;

    // two-flop synchronizer, idle high
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd_i};
    end
    assign line = sync_q[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= RX_IDLE;
            cnt_q      <= '0;
            bit_q      <= '0;
            data_o     <= '0;
            frame_ok_o <= 1'b0;
            vld_o      <= 1'b0;
        end else if (!en_i) begin
            st_q  <= RX_IDLE;
            vld_o <= 1'b0;
        end else begin
            vld_o <= 1'b0;
            unique case (st_q)
                RX_IDLE: begin
                    if (!line) begin
                        st_q  <= RX_START;
                        cnt_q <= '0;
                    end
                end
                RX_START: begin
                    if (cnt_q == CW'(HALF - 1)) begin
                        cnt_q <= '0;
                        bit_q <= '0;
                        st_q  <= line ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt_q == CW'(BIT_CYCLES - 1)) begin
                        cnt_q  <= '0;
                        data_o <= {line, data_o[7:1]};
                        bit_q  <= bit_q + 1'b1;
                        if (bit_q == 3'd7) st_q <= RX_STOP;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt_q == CW'(BIT_CYCLES - 1)) begin
                        cnt_q      <= '0;
                        frame_ok_o <= line;
                        vld_o      <= 1'b1;
                        st_q       <= RX_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/mhs_break_tx.sv
module mhs_break_tx #(
    parameter int BIT_CYCLES = 256,
    parameter int BREAK_BITS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic txd_o,
    output logic done_o
);
    localparam int TOTAL = BIT_CYCLES * BREAK_BITS;
    localparam int CW    = $clog2(TOTAL);

    logic          busy_q;
    logic [CW-1:0] cnt_q;

    assign done_o = busy_q && (cnt_q == CW'(TOTAL - 1));
    assign txd_o  = !busy_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (go_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (done_o) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mon_handshake_seq.sv
module mon_handshake_seq
    import mhs_pkg::*;
#(
    parameter int BIT_CYCLES = 256,
    parameter int NUM_BYTES  = 8,
    parameter int BREAK_BITS = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   rxd_i,
    input  logic [NUM_BYTES*8-1:0] key_i,
    output logic                   txd_o,
    output logic                   sec_pass_o,
    output logic                   cmd_ready_o
);
    localparam int IDXW = $clog2(NUM_BYTES);
    localparam int BASW = $clog2(NUM_BYTES * 8);

    seq_state_e     state_q, state_d;
    logic [IDXW-1:0] idx_q;
    logic            all_ok_q;
    logic            pass_q;
    logic            rx_vld, rx_frame_ok;
    logic [7:0]      rx_data;
    logic            brk_go, brk_done, brk_txd;
    logic            last_byte, byte_ok;
    logic [BASW-1:0] key_base;

    mhs_bit_rx #(.BIT_CYCLES(BIT_CYCLES)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (state_q == SEQ_COLLECT),
        .rxd_i      (rxd_i),
        .vld_o      (rx_vld),
        .data_o     (rx_data),
        .frame_ok_o (rx_frame_ok)
    );

    mhs_break_tx #(.BIT_CYCLES(BIT_CYCLES), .BREAK_BITS(BREAK_BITS)) u_brk (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (brk_go),
        .txd_o  (brk_txd),
        .done_o (brk_done)
    );

    assign key_base  = BASW'({idx_q, 3'b000});
    assign byte_ok   = rx_frame_ok && (rx_data == key_i[key_base +: 8]);
    assign last_byte = (idx_q == IDXW'(NUM_BYTES - 1));
    assign brk_go    = (state_q == SEQ_COLLECT) && rx_vld && last_byte;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:    if (start_i)  state_d = SEQ_COLLECT;
            SEQ_COLLECT: if (brk_go)   state_d = SEQ_BREAK;
            SEQ_BREAK:   if (brk_done) state_d = SEQ_READY;
            SEQ_READY:   state_d = SEQ_READY;
        endcase
    end

    // state register and byte bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            idx_q    <= '0;
            all_ok_q <= 1'b0;
            pass_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == SEQ_IDLE && start_i) begin
                idx_q    <= '0;
                all_ok_q <= 1'b1;
            end else if (state_q == SEQ_COLLECT && rx_vld) begin
                idx_q    <= idx_q + 1'b1;
                all_ok_q <= all_ok_q & byte_ok;
                if (last_byte) pass_q <= all_ok_q & byte_ok;
            end
        end
    end

    // outputs
    always_comb begin
        txd_o       = brk_txd;
        cmd_ready_o = (state_q == SEQ_READY);
        sec_pass_o  = pass_q;
    end
endmodule

// File: rtl/mhs_checker.sv
module mhs_checker #(
    parameter int BIT_CYCLES = 256,
    parameter int BREAK_BITS = 10
) (
    input logic clk,
    input logic rst_n,
    input logic txd_o,
    input logic sec_pass_o,
    input logic cmd_ready_o
);
    localparam int TOTAL = BIT_CYCLES * BREAK_BITS;

    int low_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)     low_cnt <= 0;
        else if (txd_o) low_cnt <= 0;
        else            low_cnt <= low_cnt + 1;
    end

    assert_break_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txd_o) |-> low_cnt == TOTAL);

    assert_ready_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready_o |=> cmd_ready_o);

    assert_ready_on_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_ready_o) |-> $rose(txd_o));

    assert_no_ready_in_break_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !txd_o |-> !cmd_ready_o);

    assert_pass_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pass_o |=> sec_pass_o);

    assert_pass_at_break_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sec_pass_o) |-> !txd_o);
endmodule

bind mon_handshake_seq mhs_checker #(
    .BIT_CYCLES (BIT_CYCLES),
    .BREAK_BITS (BREAK_BITS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .txd_o       (txd_o),
    .sec_pass_o  (sec_pass_o),
    .cmd_ready_o (cmd_ready_o)
);

// File: tb/mon_handshake_seq_tb.sv
module mon_handshake_seq_tb;
    localparam int BITC = 64;
    localparam int NB   = 8;
    localparam int BRK  = 10;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n, start_i, rxd_i;
    logic [NB*8-1:0] key_i;
    logic            txd_o, sec_pass_o, cmd_ready_o;

    mon_handshake_seq #(.BIT_CYCLES(BITC), .NUM_BYTES(NB), .BREAK_BITS(BRK)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rxd_i(rxd_i), .key_i(key_i),
        .txd_o(txd_o), .sec_pass_o(sec_pass_o), .cmd_ready_o(cmd_ready_o)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit sb_q[$];          // expected pass value per break
    bit in_brk;
    int low;
    logic [7:0] good [NB];
    logic [7:0] msg  [NB];

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: measures each break and compares with the scoreboard
    initial begin
        in_brk = 0;
        low    = 0;
        forever begin
            @(negedge clk);
            if (rst_n !== 1'b1) begin
                in_brk = 0;
                low    = 0;
            end else if (!txd_o) begin
                if (!in_brk) begin
                    in_brk = 1;
                    low    = 0;
                    check_eq("R7", "ready at break start", cmd_ready_o, 0);
                end
                low++;
            end else if (in_brk) begin
                in_brk = 0;
                if (sb_q.size() == 0) begin
                    check_eq("R5", "unexpected break", 1, 0);
                end else begin
                    bit e;
                    e = sb_q.pop_front();
                    check_eq("R6", "break length", low, BRK * BITC);
                    check_eq("R8", "pass flag at break end", sec_pass_o, e);
                    check_eq("R7", "ready when line released", cmd_ready_o, 1);
                end
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0; start_i = 1'b0; rxd_i = 1'b1;
        repeat (5) @(negedge clk);
        check_eq("R1", "txd in reset", txd_o, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "txd after reset", txd_o, 1);
        check_eq("R1", "pass after reset", sec_pass_o, 0);
        check_eq("R1", "ready after reset", cmd_ready_o, 0);
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, input logic stop);
        rxd_i = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd_i = d[i];
            repeat (BITC) @(negedge clk);
        end
        rxd_i = stop;
        repeat (BITC) @(negedge clk);
        rxd_i = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    // driver: pushes expected result, then sends the eight bytes
    task automatic run_session(input int bad_stop, input bit exp_pass, input int restart_at);
        sb_q.push_back(exp_pass);
        for (int i = 0; i < NB; i++) begin
            if (i == restart_at) pulse_start();
            send_byte(msg[i], (i == bad_stop) ? 1'b0 : 1'b1);
            if (i == NB - 2) begin
                check_eq("R5", "ready after seven bytes", cmd_ready_o, 0);
                check_eq("R5", "txd after seven bytes", txd_o, 1);
            end
        end
        for (int k = 0; k < 4 * BRK * BITC; k++) begin
            if (cmd_ready_o) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
        check_eq("R10", "ready reached", cmd_ready_o, 1);
        check_eq("R6", "txd idle after break", txd_o, 1);
        check_eq("R5", "scoreboard drained", sb_q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        good[0] = 8'h01; good[1] = 8'h80; good[2] = 8'h5A; good[3] = 8'hC3;
        good[4] = 8'h7E; good[5] = 8'h24; good[6] = 8'hFF; good[7] = 8'h00;
        for (int i = 0; i < NB; i++) key_i[8*i +: 8] = good[i];

        // S1: bytes before start ignored, glitch rejected, LSB-first match
        do_reset();
        send_byte(8'h33, 1'b1);                       // R2: before start
        check_eq("R2", "no break before start", txd_o, 1);
        pulse_start();
        rxd_i = 1'b0; repeat (4) @(negedge clk); rxd_i = 1'b1;   // R4 glitch
        repeat (2 * BITC) @(negedge clk);
        for (int i = 0; i < NB; i++) msg[i] = good[i];
        run_session(-1, 1'b1, -1);
        check_eq("R3", "pass with LSB-first bytes", sec_pass_o, 1);
        check_eq("R4", "glitch not taken as start", sec_pass_o, 1);
        pulse_start();                                // R2: start after ready
        repeat (3 * BITC) @(negedge clk);
        check_eq("R2", "ready kept after late start", cmd_ready_o, 1);
        check_eq("R2", "pass kept after late start", sec_pass_o, 1);
        check_eq("R2", "txd kept after late start", txd_o, 1);

        // S2: one data mismatch
        do_reset();
        pulse_start();
        for (int i = 0; i < NB; i++) msg[i] = good[i];
        msg[3] = msg[3] ^ 8'h10;
        run_session(-1, 1'b0, -1);
        check_eq("R10", "pass low after mismatch", sec_pass_o, 0);

        // S3: framing error on the eighth byte, data correct
        do_reset();
        pulse_start();
        for (int i = 0; i < NB; i++) msg[i] = good[i];
        run_session(NB - 1, 1'b0, -1);
        check_eq("R9", "pass low after framing error", sec_pass_o, 0);

        // S4: start pulse during collection does not restart the count
        do_reset();
        pulse_start();
        for (int i = 0; i < NB; i++) msg[i] = good[i];
        run_session(-1, 1'b1, 3);
        check_eq("R2", "pass after mid-collection start", sec_pass_o, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule